// File: doc/BRIEF.md
# Predicated Vector Floating-Point Round-to-Integral Unit

This unit takes a 128-bit vector of IEEE floating-point lanes and rounds every lane to an integral value, leaving each result in the same floating-point format. The vector is read either as eight 16-bit half-precision lanes or as four 32-bit single-precision lanes. A 3-bit operation code picks one of five fixed rounding directions, or it picks the ambient rounding mode, which is the only variant that reports inexact results.

A 16-bit byte predicate controls the write-back. Each destination byte takes the rounded value only where its predicate bit is set, and otherwise keeps the old destination byte supplied with the request. The lowest predicate bit of a lane decides whether that lane's exception flags are recorded. Half-precision and single-precision lanes each have their own ambient rounding mode and their own sticky flag register. A request with a bad size code or a bad operation code is reported as illegal and changes nothing.

A request is presented for one cycle with `inValid`. The merged vector, the illegal indication and the updated flags appear on the next cycle, and `outValid` is high for that cycle.

Top module: `vrnd_top`

## Requirements
- R1: Size code 1 treats the vector as eight half-precision lanes, and size code 2 as four single-precision lanes. Lane k occupies bits [16k+15:16k] or [32k+31:32k], with lane 0 in the least significant bits.
- R2: Size code 0 or 3, or operation code 100 or 110, makes `illegalOut` high with `outValid`. In that case `dstVec` equals the old destination vector and no flag changes.
- R3: Operation codes select a fixed rounding direction: 000 to nearest with ties to even, 010 to nearest with ties away from zero, 011 toward zero, 101 toward minus infinity, 111 toward plus infinity.
- R4: Operation 001 rounds with the ambient mode of the lane width's own context (`ambRmHalf` or `ambRmSingle`). The ambient encoding is 00 nearest-even, 01 toward plus infinity, 10 toward minus infinity, 11 toward zero.
- R5: Flag bit 0 is inexact. It is raised only by operation 001, and only when the rounded value differs from the input. The fixed-direction operations never raise it.
- R6: Any NaN input returns the default quiet NaN (0x7E00 for half, 0x7FC00000 for single). Flag bit 1, invalid, is raised only for a signalling NaN. Infinities and zeros are returned unchanged.
- R7: A finite input whose magnitude is at least 2^10 (half) or 2^23 (single) is returned unchanged. A result that rounds to zero keeps the sign of the input, and subnormal inputs round like any other value below one.
- R8: Destination byte i takes the rounded byte when `predMask[i]` is 1 and the old byte when it is 0.
- R9: A lane's flags are recorded only when the lowest predicate bit of that lane is set. A lane with some other predicate bit set still merges its result but records no flags. A lane with all predicate bits clear has no effect at all.
- R10: Half-lane flags accumulate only into `flagsHalf`, and single-lane flags only into `flagsSingle`.
- R11: Outputs are registered. Results appear one cycle after `inValid` with `outValid` high for that cycle. `dstVec` holds its value when there is no request. Flags are sticky until reset. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request strobe |
| sizeCode | input | 2 | Lane size code |
| opSel | input | 3 | Rounding operation select |
| ambRmHalf | input | 2 | Ambient rounding mode, half context |
| ambRmSingle | input | 2 | Ambient rounding mode, single context |
| predMask | input | 16 | Per-byte predicate |
| srcVec | input | 128 | Source vector |
| oldVec | input | 128 | Old destination vector |
| outValid | output | 1 | Result strobe |
| illegalOut | output | 1 | Illegal encoding indication |
| dstVec | output | 128 | Merged destination vector |
| flagsHalf | output | 2 | Sticky flags {invalid, inexact}, half context |
| flagsSingle | output | 2 | Sticky flags {invalid, inexact}, single context |

## Verification
The bench targets exact ties, where a design that mixes up even-tie and away-tie rounding returns 2.0 or 3.0 for 2.5 in the wrong mode. It also covers values below one, where a wrong sign path would turn -0.5 into +0, and subnormals under directed rounding, where a design that flushes them would fail to produce ±1.0. It drives signalling and quiet NaNs, so a design that flags every NaN, or that never quiets one, shows up. Partial predicates test whether the flag gating follows the lowest byte of a lane or merely any active byte. Ambient requests with different modes and flags in the two contexts show whether the design shares one context between both lane widths.

// File: rtl/vrnd_pkg.sv
package vrnd_pkg;
  localparam int HALF_EXP_W = 5;
  localparam int HALF_MAN_W = 10;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_MAN_W  = 23;
  localparam int FLAG_W     = 2;   // bit 0 inexact, bit 1 invalid

  typedef enum logic [2:0] {
    RND_NEAR_EVEN,
    RND_NEAR_AWAY,
    RND_ZERO,
    RND_DOWN,
    RND_UP
  } rndModeT;

  typedef struct packed {
    logic    fire;           // legal request this cycle
    logic    bad;            // illegal request this cycle
    logic    halfSel;        // half-precision lanes selected
    rndModeT mode;           // resolved rounding direction
    logic    reportInexact;  // ambient variant reports inexact
  } ctrlStrobeT;
endpackage

// File: rtl/vrnd_ctrl.sv
module vrnd_ctrl
  import vrnd_pkg::*;
(
  input  logic       inValid,
  input  logic [1:0] sizeCode,
  input  logic [2:0] opSel,
  input  logic [1:0] ambRmHalf,
  input  logic [1:0] ambRmSingle,
  output ctrlStrobeT strobe
);
  function automatic rndModeT ambToMode(input logic [1:0] amb);
    case (amb)
      2'b00:   return RND_NEAR_EVEN;
      2'b01:   return RND_UP;
      2'b10:   return RND_DOWN;
      default: return RND_ZERO;
    endcase
  endfunction

  logic sizeOk;
  logic opOk;
  logic halfSel;

  always_comb begin
    halfSel = (sizeCode == 2'd1);
    sizeOk  = halfSel || (sizeCode == 2'd2);
    opOk    = 1'b1;
    strobe.reportInexact = 1'b0;
    strobe.mode = RND_NEAR_EVEN;
    case (opSel)
      3'b000: strobe.mode = RND_NEAR_EVEN;
      3'b001: begin
        strobe.mode = halfSel ? ambToMode(ambRmHalf) : ambToMode(ambRmSingle);
        strobe.reportInexact = 1'b1;
      end
      3'b010: strobe.mode = RND_NEAR_AWAY;
      3'b011: strobe.mode = RND_ZERO;
      3'b101: strobe.mode = RND_DOWN;
      3'b111: strobe.mode = RND_UP;
      default: opOk = 1'b0;
    endcase
    strobe.halfSel = halfSel;
    strobe.fire    = inValid && sizeOk && opOk;
    strobe.bad     = inValid && !(sizeOk && opOk);
  end
endmodule

// File: rtl/vrnd_lane.sv
module vrnd_lane
  import vrnd_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10
) (
  input  logic [EXP_W+MAN_W:0] laneIn,
  input  rndModeT              mode,
  input  logic                 reportInexact,
  output logic [EXP_W+MAN_W:0] laneOut,
  output logic                 flagInvalid,
  output logic                 flagInexact
);
  localparam int MAG_W     = EXP_W + MAN_W;
  localparam int BIAS      = (1 << (EXP_W - 1)) - 1;
  localparam int INT_LIMIT = BIAS + MAN_W;
  localparam logic [MAG_W-1:0] ONE      = MAG_W'(1);
  localparam logic [MAG_W-1:0] UNIT_MAG = MAG_W'(BIAS) << MAN_W;
  localparam logic [MAG_W:0]   QNAN     = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic             sgn;
  logic [EXP_W-1:0] expF;
  logic [MAN_W-1:0] manF;
  logic [MAG_W-1:0] mag;
  logic [MAG_W-1:0] lowMask;
  logic [MAG_W-1:0] trunc;
  int               expI;
  int               shiftAmt;
  logic             halfBit;
  logic             stickyBit;
  logic             lsbBit;
  logic             belowOne;
  logic             inexact;
  logic             roundUp;

  // split the magnitude into kept integer bits, the half bit and the rest
  always_comb begin
    sgn       = laneIn[MAG_W];
    expF      = laneIn[MAG_W-1:MAN_W];
    manF      = laneIn[MAN_W-1:0];
    mag       = laneIn[MAG_W-1:0];
    expI      = int'(expF);
    shiftAmt  = 0;
    lowMask   = '0;
    trunc     = mag;
    halfBit   = 1'b0;
    stickyBit = 1'b0;
    lsbBit    = 1'b0;
    belowOne  = 1'b0;
    if (expI < BIAS) begin
      belowOne  = 1'b1;
      halfBit   = (expI == BIAS - 1);
      stickyBit = halfBit ? |manF : |mag;
    end else if (expI < INT_LIMIT) begin
      shiftAmt  = INT_LIMIT - expI;
      lowMask   = (ONE << shiftAmt) - ONE;
      halfBit   = |(mag & (ONE << (shiftAmt - 1)));
      stickyBit = |(mag & (lowMask >> 1));
      lsbBit    = (shiftAmt == MAN_W) || (|(mag & (ONE << shiftAmt)));
      trunc     = mag & ~lowMask;
    end
  end

  always_comb begin
    inexact = halfBit | stickyBit;
    case (mode)
      RND_NEAR_EVEN: roundUp = halfBit & (stickyBit | lsbBit);
      RND_NEAR_AWAY: roundUp = halfBit;
      RND_DOWN:      roundUp = sgn & inexact;
      RND_UP:        roundUp = ~sgn & inexact;
      default:       roundUp = 1'b0;
    endcase
  end

  always_comb begin
    laneOut     = laneIn;
    flagInvalid = 1'b0;
    flagInexact = 1'b0;
    if (expF == {EXP_W{1'b1}}) begin
      if (|manF) begin
        laneOut     = QNAN;
        flagInvalid = ~manF[MAN_W-1];
      end
    end else if (expI < INT_LIMIT) begin
      flagInexact = reportInexact & inexact;
      if (belowOne)
        laneOut = {sgn, roundUp ? UNIT_MAG : {MAG_W{1'b0}}};
      else
        laneOut = {sgn, trunc + (roundUp ? (ONE << shiftAmt) : {MAG_W{1'b0}})};
    end
  end
endmodule

// File: rtl/vrnd_datapath.sv
module vrnd_datapath
  import vrnd_pkg::*;
#(
  parameter int VEC_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobeT             strobe,
  input  logic [VEC_BYTES-1:0]   predMask,
  input  logic [VEC_BYTES*8-1:0] srcVec,
  input  logic [VEC_BYTES*8-1:0] oldVec,
  output logic                   outValid,
  output logic                   illegalOut,
  output logic [VEC_BYTES*8-1:0] dstVec,
  output logic [FLAG_W-1:0]      flagsHalf,
  output logic [FLAG_W-1:0]      flagsSingle
);
  localparam int VEC_W      = VEC_BYTES * 8;
  localparam int HALF_W     = 1 + HALF_EXP_W + HALF_MAN_W;
  localparam int SGL_W      = 1 + SGL_EXP_W + SGL_MAN_W;
  localparam int HALF_BYTES = HALF_W / 8;
  localparam int SGL_BYTES  = SGL_W / 8;
  localparam int HALF_LANES = VEC_BYTES / HALF_BYTES;
  localparam int SGL_LANES  = VEC_BYTES / SGL_BYTES;

  logic [VEC_W-1:0]      resHalf;
  logic [VEC_W-1:0]      resSgl;
  logic [VEC_W-1:0]      resSel;
  logic [VEC_W-1:0]      merged;
  logic [HALF_LANES-1:0] invHalf;
  logic [HALF_LANES-1:0] inxHalf;
  logic [SGL_LANES-1:0]  invSgl;
  logic [SGL_LANES-1:0]  inxSgl;

  for (genvar h = 0; h < HALF_LANES; h++) begin : g_half
    logic laneInv;
    logic laneInx;
    vrnd_lane #(.EXP_W(HALF_EXP_W), .MAN_W(HALF_MAN_W)) lane_i (
      .laneIn       (srcVec[h*HALF_W +: HALF_W]),
      .mode         (strobe.mode),
      .reportInexact(strobe.reportInexact),
      .laneOut      (resHalf[h*HALF_W +: HALF_W]),
      .flagInvalid  (laneInv),
      .flagInexact  (laneInx)
    );
    assign invHalf[h] = laneInv & predMask[h*HALF_BYTES];
    assign inxHalf[h] = laneInx & predMask[h*HALF_BYTES];
  end

  for (genvar s = 0; s < SGL_LANES; s++) begin : g_sgl
    logic laneInv;
    logic laneInx;
    vrnd_lane #(.EXP_W(SGL_EXP_W), .MAN_W(SGL_MAN_W)) lane_i (
      .laneIn       (srcVec[s*SGL_W +: SGL_W]),
      .mode         (strobe.mode),
      .reportInexact(strobe.reportInexact),
      .laneOut      (resSgl[s*SGL_W +: SGL_W]),
      .flagInvalid  (laneInv),
      .flagInexact  (laneInx)
    );
    assign invSgl[s] = laneInv & predMask[s*SGL_BYTES];
    assign inxSgl[s] = laneInx & predMask[s*SGL_BYTES];
  end

  assign resSel = strobe.halfSel ? resHalf : resSgl;

  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_merge
    assign merged[b*8 +: 8] = predMask[b] ? resSel[b*8 +: 8] : oldVec[b*8 +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      illegalOut  <= 1'b0;
      dstVec      <= '0;
      flagsHalf   <= '0;
      flagsSingle <= '0;
    end else begin
      outValid   <= strobe.fire | strobe.bad;
      illegalOut <= strobe.bad;
      if (strobe.fire) begin
        dstVec <= merged;
        if (strobe.halfSel)
          flagsHalf <= flagsHalf | {(|invHalf), (|inxHalf)};
        else
          flagsSingle <= flagsSingle | {(|invSgl), (|inxSgl)};
      end else if (strobe.bad) begin
        dstVec <= oldVec;
      end
    end
  end
endmodule

// File: rtl/vrnd_top.sv
module vrnd_top
  import vrnd_pkg::*;
#(
  parameter int VEC_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic [1:0]             sizeCode,
  input  logic [2:0]             opSel,
  input  logic [1:0]             ambRmHalf,
  input  logic [1:0]             ambRmSingle,
  input  logic [VEC_BYTES-1:0]   predMask,
  input  logic [VEC_BYTES*8-1:0] srcVec,
  input  logic [VEC_BYTES*8-1:0] oldVec,
  output logic                   outValid,
  output logic                   illegalOut,
  output logic [VEC_BYTES*8-1:0] dstVec,
  output logic [FLAG_W-1:0]      flagsHalf,
  output logic [FLAG_W-1:0]      flagsSingle
);
  ctrlStrobeT strobe;

  vrnd_ctrl ctrl_i (
    .inValid    (inValid),
    .sizeCode   (sizeCode),
    .opSel      (opSel),
    .ambRmHalf  (ambRmHalf),
    .ambRmSingle(ambRmSingle),
    .strobe     (strobe)
  );

  vrnd_datapath #(.VEC_BYTES(VEC_BYTES)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .predMask   (predMask),
    .srcVec     (srcVec),
    .oldVec     (oldVec),
    .outValid   (outValid),
    .illegalOut (illegalOut),
    .dstVec     (dstVec),
    .flagsHalf  (flagsHalf),
    .flagsSingle(flagsSingle)
  );
endmodule

// File: rtl/vrnd_chk.sv
module vrnd_chk #(
  parameter int VEC_BYTES = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   inValid,
  input logic [1:0]             sizeCode,
  input logic [2:0]             opSel,
  input logic [VEC_BYTES-1:0]   predMask,
  input logic [VEC_BYTES*8-1:0] oldVec,
  input logic                   outValid,
  input logic                   illegalOut,
  input logic [VEC_BYTES*8-1:0] dstVec,
  input logic [1:0]             flagsHalf,
  input logic [1:0]             flagsSingle
);
  logic badReq;
  assign badReq = (sizeCode == 2'd0) || (sizeCode == 2'd3) ||
                  (opSel == 3'b100) || (opSel == 3'b110);

  assert_out_follows_in_R11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (outValid == $past(inValid)));

  assert_illegal_has_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    illegalOut |-> outValid);

  assert_illegal_keeps_old_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && badReq) |=> (illegalOut && dstVec == $past(oldVec) &&
                             $stable(flagsHalf) && $stable(flagsSingle)));

  assert_empty_mask_keeps_old_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !badReq && predMask == '0) |=>
      (dstVec == $past(oldVec) && $stable(flagsHalf) && $stable(flagsSingle)));

  assert_half_ctx_only_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sizeCode == 2'd1) |=> $stable(flagsSingle));

  assert_single_ctx_only_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sizeCode == 2'd2) |=> $stable(flagsHalf));

  assert_flags_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((flagsHalf & $past(flagsHalf)) == $past(flagsHalf)) &&
              ((flagsSingle & $past(flagsSingle)) == $past(flagsSingle))));

  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(dstVec) && $stable(flagsHalf) && $stable(flagsSingle) && !illegalOut));
endmodule

bind vrnd_top vrnd_chk #(.VEC_BYTES(VEC_BYTES)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .sizeCode   (sizeCode),
  .opSel      (opSel),
  .predMask   (predMask),
  .oldVec     (oldVec),
  .outValid   (outValid),
  .illegalOut (illegalOut),
  .dstVec     (dstVec),
  .flagsHalf  (flagsHalf),
  .flagsSingle(flagsSingle)
);

// File: tb/vrnd_top_tb_top.sv
module vrnd_top_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [1:0]   sizeCode = 2'd1;
  logic [2:0]   opSel = 3'b000;
  logic [1:0]   ambRmHalf = 2'b00;
  logic [1:0]   ambRmSingle = 2'b00;
  logic [15:0]  predMask = '0;
  logic [127:0] srcVec = '0;
  logic [127:0] oldVec = '0;
  logic         outValid;
  logic         illegalOut;
  logic [127:0] dstVec;
  logic [1:0]   flagsHalf;
  logic [1:0]   flagsSingle;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  vrnd_top dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sizeCode(sizeCode),
    .opSel(opSel), .ambRmHalf(ambRmHalf), .ambRmSingle(ambRmSingle),
    .predMask(predMask), .srcVec(srcVec), .oldVec(oldVec),
    .outValid(outValid), .illegalOut(illegalOut), .dstVec(dstVec),
    .flagsHalf(flagsHalf), .flagsSingle(flagsSingle)
  );

  typedef struct packed {
    logic [1:0]  sz;
    logic [2:0]  op;
    logic [1:0]  amb;
    logic [31:0] src;
    logic [31:0] res;
    logic [1:0]  fl;   // {invalid, inexact}
  } rowT;

  localparam int ROWS = 24;
  localparam rowT TABLE [ROWS] = '{
    '{2'd1, 3'b000, 2'b00, 32'h4100, 32'h4000, 2'b00},          // R3 tie to even
    '{2'd1, 3'b010, 2'b00, 32'h4100, 32'h4200, 2'b00},          // R3 tie away
    '{2'd1, 3'b011, 2'b00, 32'hBE00, 32'hBC00, 2'b00},          // R3 toward zero
    '{2'd1, 3'b101, 2'b00, 32'h3E00, 32'h3C00, 2'b00},          // R3 toward -inf
    '{2'd1, 3'b101, 2'b00, 32'hBE00, 32'hC000, 2'b00},          // R3 toward -inf negative
    '{2'd1, 3'b111, 2'b00, 32'h3E00, 32'h4000, 2'b00},          // R3 toward +inf
    '{2'd1, 3'b001, 2'b00, 32'h3E00, 32'h4000, 2'b01},          // R4 R5 ambient nearest
    '{2'd1, 3'b001, 2'b11, 32'h4100, 32'h4000, 2'b01},          // R4 R5 ambient zero
    '{2'd1, 3'b000, 2'b00, 32'h3800, 32'h0000, 2'b00},          // R7 half to +0
    '{2'd1, 3'b011, 2'b00, 32'hB800, 32'h8000, 2'b00},          // R7 sign kept
    '{2'd1, 3'b000, 2'b00, 32'h7C01, 32'h7E00, 2'b10},          // R6 signalling NaN
    '{2'd1, 3'b000, 2'b00, 32'hFE00, 32'h7E00, 2'b00},          // R6 quiet NaN
    '{2'd1, 3'b111, 2'b00, 32'hFC00, 32'hFC00, 2'b00},          // R6 infinity kept
    '{2'd1, 3'b001, 2'b00, 32'h6401, 32'h6401, 2'b00},          // R7 large integral
    '{2'd1, 3'b111, 2'b00, 32'h0001, 32'h3C00, 2'b00},          // R7 subnormal up
    '{2'd1, 3'b101, 2'b00, 32'h8001, 32'hBC00, 2'b00},          // R7 negative subnormal
    '{2'd2, 3'b000, 2'b00, 32'h3FC00000, 32'h40000000, 2'b00},  // R1 R3 single
    '{2'd2, 3'b010, 2'b00, 32'hC0200000, 32'hC0400000, 2'b00},  // R3 tie away negative
    '{2'd2, 3'b101, 2'b00, 32'h3E99999A, 32'h00000000, 2'b00},  // R3 R7 below one
    '{2'd2, 3'b111, 2'b00, 32'h3E99999A, 32'h3F800000, 2'b00},  // R3 up to one
    '{2'd2, 3'b001, 2'b01, 32'h40200000, 32'h40400000, 2'b01},  // R4 ambient +inf
    '{2'd2, 3'b001, 2'b10, 32'hBF000000, 32'hBF800000, 2'b01},  // R4 ambient -inf
    '{2'd2, 3'b001, 2'b00, 32'h40400000, 32'h40400000, 2'b00},  // R5 exact, no inexact
    '{2'd2, 3'b000, 2'b00, 32'hFF800001, 32'h7FC00000, 2'b10}   // R6 single sNaN
  };

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runOp(input logic [1:0] sz, input logic [2:0] op,
                       input logic [1:0] ah, input logic [1:0] as,
                       input logic [15:0] m, input logic [127:0] s,
                       input logic [127:0] o);
    @(negedge clk);
    sizeCode = sz; opSel = op; ambRmHalf = ah; ambRmSingle = as;
    predMask = m; srcVec = s; oldVec = o; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  function automatic logic [127:0] mergeBytes(input logic [127:0] nw, input logic [127:0] old,
                                              input logic [15:0] m);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[i*8 +: 8] = m[i] ? nw[i*8 +: 8] : old[i*8 +: 8];
    return r;
  endfunction

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] src;
    logic [127:0] exp;
    logic [127:0] old;
    repeat (2) @(negedge clk);
    // R11 reset state
    check("R11 reset dstVec", dstVec, '0);
    check("R11 reset flags/strobes", {124'd0, outValid, illegalOut, flagsHalf}, '0);
    check("R11 reset flagsSingle", {126'd0, flagsSingle}, '0);
    rstN = 1'b1;

    // table walk: R3 R4 R5 R6 R7 with full predicate
    for (int r = 0; r < ROWS; r++) begin
      doReset();
      src = (TABLE[r].sz == 2'd1) ? {8{TABLE[r].src[15:0]}} : {4{TABLE[r].src}};
      exp = (TABLE[r].sz == 2'd1) ? {8{TABLE[r].res[15:0]}} : {4{TABLE[r].res}};
      runOp(TABLE[r].sz, TABLE[r].op, TABLE[r].amb, TABLE[r].amb, 16'hFFFF, src, '0);
      check($sformatf("table row %0d result", r), dstVec, exp);
      if (TABLE[r].sz == 2'd1)
        check($sformatf("table row %0d flags", r), {124'd0, flagsSingle, flagsHalf}, {126'd0, TABLE[r].fl});
      else
        check($sformatf("table row %0d flags", r), {124'd0, flagsHalf, flagsSingle}, {126'd0, TABLE[r].fl});
      check($sformatf("table row %0d valid R11", r), {126'd0, outValid, illegalOut}, 128'd2);
    end

    // R1 distinct single lanes, lane 0 in the low bits
    doReset();
    runOp(2'd2, 3'b000, 2'b00, 2'b00, 16'hFFFF,
          {32'h3F800000, 32'h3E99999A, 32'hBFC00000, 32'h40200000}, '0);
    check("R1 single lane order", dstVec,
          {32'h3F800000, 32'h00000000, 32'hC0000000, 32'h40000000});

    // R1 distinct half lanes
    runOp(2'd1, 3'b011, 2'b00, 2'b00, 16'hFFFF,
          {16'h3C00, 16'h4100, 16'hBE00, 16'h3800, 16'h4200, 16'h0000, 16'h8000, 16'h3E00}, '0);
    check("R1 half lane order", dstVec,
          {16'h3C00, 16'h4000, 16'hBC00, 16'h0000, 16'h4200, 16'h0000, 16'h8000, 16'h3C00});

    // R8 byte merge with a scattered predicate
    old = {8{16'hA55A}};
    runOp(2'd1, 3'b000, 2'b00, 2'b00, 16'b0110_1001_0011_1100, {8{16'h4100}}, old);
    check("R8 byte merge", dstVec, mergeBytes({8{16'h4000}}, old, 16'b0110_1001_0011_1100));

    // R9 flags dropped when lane's low byte is unpredicated
    doReset();
    src = {{7{16'h3C00}}, 16'h7C01};
    old = {16{8'h33}};
    runOp(2'd1, 3'b000, 2'b00, 2'b00, 16'hFFFE, src, old);
    check("R9 partial lane merged", dstVec, mergeBytes({{7{16'h3C00}}, 16'h7E00}, old, 16'hFFFE));
    check("R9 partial lane no flags", {126'd0, flagsHalf}, 128'd0);
    runOp(2'd1, 3'b000, 2'b00, 2'b00, 16'hFFFC, src, old);
    check("R9 empty lane untouched", dstVec, mergeBytes({{7{16'h3C00}}, 16'h7E00}, old, 16'hFFFC));
    check("R9 empty lane no flags", {126'd0, flagsHalf}, 128'd0);
    runOp(2'd1, 3'b000, 2'b00, 2'b00, 16'h0001, src, old);
    check("R9 low byte records flag", {126'd0, flagsHalf}, 128'd2);
    check("R9 low byte merged", dstVec, mergeBytes({{7{16'h3C00}}, 16'h7E00}, old, 16'h0001));

    // R10 separate contexts, R4 per-context ambient, R11 sticky
    doReset();
    runOp(2'd2, 3'b000, 2'b01, 2'b01, 16'hFFFF, {4{32'h7F800001}}, '0);
    check("R10 single flags", {124'd0, flagsHalf, flagsSingle}, 128'd2);
    runOp(2'd1, 3'b001, 2'b11, 2'b01, 16'hFFFF, {8{16'h3E00}}, '0);
    check("R4 half uses own ambient", dstVec, {8{16'h3C00}});
    check("R10 half flags, single sticky R11", {124'd0, flagsHalf, flagsSingle}, 128'h6);

    // R2 illegal size and operation codes
    old = {8{16'h1234}};
    runOp(2'd3, 3'b000, 2'b00, 2'b00, 16'hFFFF, {8{16'h4100}}, old);
    check("R2 size 3 illegal", {126'd0, outValid, illegalOut}, 128'd3);
    check("R2 size 3 keeps old", dstVec, old);
    runOp(2'd0, 3'b000, 2'b00, 2'b00, 16'hFFFF, {8{16'h4100}}, '0);
    check("R2 size 0 illegal", {126'd0, outValid, illegalOut}, 128'd3);
    runOp(2'd1, 3'b100, 2'b00, 2'b00, 16'hFFFF, {8{16'h7C01}}, old);
    check("R2 op 100 keeps old", dstVec, old);
    runOp(2'd2, 3'b110, 2'b00, 2'b00, 16'hFFFF, {4{32'h7F800001}}, old);
    check("R2 op 110 illegal", {126'd0, outValid, illegalOut}, 128'd3);
    check("R2 flags untouched", {124'd0, flagsHalf, flagsSingle}, 128'h6);

    // R11 idle: output strobe drops, result held
    @(negedge clk);
    check("R11 idle strobe low", {126'd0, outValid, illegalOut}, 128'd0);
    check("R11 idle result held", dstVec, old);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule